// File: doc/BRIEF.md
# Burst Bus Initiator with Two-Sided Ready Handshake

This block is the initiator end of a shared, multiplexed address/data burst bus. A local client hands it one request at a time: a direction, a start byte address and a word count. The block then owns the bus for one burst. It opens the burst with a single address phase, in which it drives the address and a command code on the shared lines while the cycle-active line is high. After that comes a data phase in which one word moves on every clock edge where both the initiator-ready and target-ready lines are high.

Write words arrive on a valid/ready stream and read words leave on another. Back-pressure on either stream turns directly into initiator wait states. A write word is consumed only on the edge where it crosses the bus. A read word is offered only while the target holds its ready high. The cycle-active line drops once a single word remains, so the target can see that the burst is ending. A read burst places one undriven turnaround cycle between the address phase and the first data word. The target can cut the burst short with its stop line. Loss of grant also ends the burst early, one word after it is seen. Each burst closes with a one-cycle completion pulse that carries an end code, the count of words still outstanding and the byte address at which a follow-up burst would resume. While grant stays parked high, the next request can start without any new arbitration.

Top module: `burst_initiator`

## Requirements
- R1: A request is accepted (`req_ready_o` high) only while the block is idle and `grant_i` is high. With grant low, a pending request is held off and the bus stays inactive. The request length must be at least one word.
- R2: In the cycle after acceptance the block is in its address phase: `bus_cyc_o` high, `bus_ad_oe_o` high, `bus_ad_o` equal to the start address and `bus_cmd_o` set to 2'b10 for a write or 2'b01 for a read. Outside the address phase `bus_cmd_o` is 2'b00.
- R3: During write data cycles the block drives the current write-stream word on `bus_ad_o` with `bus_ad_oe_o` high. Write words go out in stream order. During read data cycles, `rd_data_o` carries `bus_ad_i`.
- R4: A data word moves only in a cycle where `init_rdy_o` and `tgt_rdy_i` are both high. While `tgt_rdy_i` is low, `wr_ready_o` and `rd_valid_o` are low and no word is consumed.
- R5: In the data phase `bus_cyc_o` is high exactly while more than one word remains and the burst is not being cut by grant loss. It is low throughout the cycles of the final word.
- R6: A read burst has exactly one turnaround cycle after its address phase. In that cycle `bus_cyc_o` is high and `bus_ad_oe_o` is low. `bus_ad_oe_o` stays low for the whole of a read data phase.
- R7: In the data phase `init_rdy_o` equals `wr_valid_i` for a write and `rd_ready_i` for a read.
- R8: `done_o` pulses for one cycle, in the cycle after the edge that ends the burst. When every word has moved, `done_status_o` is 0 (complete), `done_left_o` is 0 and `done_addr_o` equals the start address plus 4 times the words moved.
- R9: `tgt_stop_i` high in a data cycle ends the burst at that edge. A word that moves on the same edge counts. If no word moved in the whole burst, the status is 1 (retry). Otherwise it is 2 (disconnect). In both cases `done_left_o` holds the words not moved and `done_addr_o` the resume address.
- R10: If `grant_i` is low at an edge during a burst, `bus_cyc_o` is low from the next cycle, and the next word to move is the last one. The status is 3 (preempted) when words remain and 0 when none do.
- R11: In the completion cycle `bus_cyc_o` and `bus_ad_oe_o` are low. In the cycle after it, with grant still high, a new request is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Request taken this cycle |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| req_addr_i | input | DW | Start byte address |
| req_len_i | input | LW | Word count, at least 1 |
| wr_valid_i | input | 1 | Write stream word present |
| wr_ready_o | output | 1 | Write word consumed this cycle |
| wr_data_i | input | DW | Write stream word |
| rd_valid_o | output | 1 | Read stream word present |
| rd_ready_i | input | 1 | Read stream sink can take a word |
| rd_data_o | output | DW | Read stream word |
| grant_i | input | 1 | Bus grant from the arbiter |
| bus_cyc_o | output | 1 | Burst-active line, dropped for the final word |
| bus_cmd_o | output | 2 | Command code during the address phase |
| bus_ad_o | output | DW | Shared address/data lines, outgoing value |
| bus_ad_oe_o | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | DW | Shared address/data lines, incoming value |
| init_rdy_o | output | 1 | Initiator ready for the current word |
| tgt_rdy_i | input | 1 | Target ready for the current word |
| tgt_stop_i | input | 1 | Target request to end the burst |
| done_o | output | 1 | One-cycle burst completion pulse |
| done_status_o | output | 2 | End code: 0 complete, 1 retry, 2 disconnect, 3 preempted |
| done_left_o | output | LW | Words not moved |
| done_addr_o | output | DW | Resume byte address |

## Verification
The bench aims at the cycle where the burst-active line falls. A design that drops it one word early or late would show the wrong level in the final data cycle, and that includes the single-word burst, where the line must already be low in the first data cycle. It applies a target stop with and without a word moving on the same edge, and a stop before any word has moved. A design that confuses retry with disconnect, or that miscounts the word caught by the stop, would report the wrong end code, remaining count or resume address. It stalls each side in turn: a design that lets a word slip through while only one side is ready would emit or consume an extra stream word and misalign the data that follows. It also drops grant in mid-burst and restarts at once on a parked grant. A design that ignored grant loss would keep the burst-active line high, and one that needed a fresh grant edge would hold the next request off.

// File: rtl/bbi_pkg.sv
package bbi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_DATA,
    ST_DONE
  } bbi_state_e;

  typedef enum logic [1:0] {
    END_OK      = 2'd0,
    END_RETRY   = 2'd1,
    END_DISC    = 2'd2,
    END_PREEMPT = 2'd3
  } bbi_end_e;

  localparam logic [1:0] CMD_NONE = 2'b00;
  localparam logic [1:0] CMD_RD   = 2'b01;
  localparam logic [1:0] CMD_WR   = 2'b10;

endpackage

// File: rtl/bbi_tracker.sv
module bbi_tracker #(
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          step_i,
  output logic [DW-1:0] addr_o,
  output logic [LW-1:0] left_o,
  output logic          moved_o,
  output logic          last_o
);
  localparam int unsigned STEP_BYTES = DW / 8;
  localparam logic [DW-1:0] ADDR_INC = DW'(STEP_BYTES);
  localparam logic [LW-1:0] ONE_WORD = LW'(1);

  logic [DW-1:0] addr_q;
  logic [LW-1:0] left_q;
  logic          moved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      moved_q <= 1'b0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      left_q  <= len_i;
      moved_q <= 1'b0;
    end else if (step_i) begin
      addr_q  <= addr_q + ADDR_INC;
      left_q  <= left_q - ONE_WORD;
      moved_q <= 1'b1;
    end
  end

  assign addr_o  = addr_q;
  assign left_o  = left_q;
  assign moved_o = moved_q;
  assign last_o  = (left_q == ONE_WORD);

  // R4: a word can only move while at least one is still owed
  a_r4_step_needs_left: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (left_q != '0));

  // R8: every moved word advances the resume address by one word
  a_r8_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (addr_q == $past(addr_q) + ADDR_INC));

endmodule

// File: rtl/bbi_seq.sv
module bbi_seq
  import bbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  input  logic       req_write_i,
  input  logic       grant_i,
  input  logic       loc_rdy_i,
  input  logic       tgt_rdy_i,
  input  logic       tgt_stop_i,
  input  logic       last_i,
  input  logic       moved_i,
  output bbi_state_e state_o,
  output logic       write_o,
  output logic       quit_o,
  output logic       load_o,
  output logic       step_o,
  output logic [1:0] status_o
);
  bbi_state_e state_q, state_d;
  logic       write_q;
  logic       quit_q;
  bbi_end_e   status_q, status_d;
  logic       in_data;
  logic       finish;
  logic       active;

  assign in_data = (state_q == ST_DATA);
  assign load_o  = (state_q == ST_IDLE) && req_valid_i && grant_i;
  assign step_o  = in_data && loc_rdy_i && tgt_rdy_i;
  assign finish  = in_data && (tgt_stop_i || (step_o && (last_i || quit_q)));
  assign active  = (state_q == ST_ADDR) || (state_q == ST_TURN) || in_data;

  always_comb begin
    if (step_o && last_i)
      status_d = END_OK;
    else if (tgt_stop_i)
      status_d = (!moved_i && !step_o) ? END_RETRY : END_DISC;
    else
      status_d = END_PREEMPT;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_ADDR;
      ST_ADDR: state_d = write_q ? ST_DATA : ST_TURN;
      ST_TURN: state_d = ST_DATA;
      ST_DATA: if (finish) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      write_q  <= 1'b0;
      quit_q   <= 1'b0;
      status_q <= END_OK;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        write_q <= req_write_i;
        quit_q  <= 1'b0;
      end else if (active && !grant_i) begin
        quit_q <= 1'b1;
      end
      if (finish) status_q <= status_d;
    end
  end

  assign state_o  = state_q;
  assign write_o  = write_q;
  assign quit_o   = quit_q;
  assign status_o = status_q;

  // R8: the completion cycle lasts exactly one cycle
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R9: a stop in a data cycle closes the burst at that edge
  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && tgt_stop_i) |=> (state_q == ST_DONE));

  // R9: retry is only reported when no word ever moved
  a_r9_retry_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && status_q == END_RETRY) |-> !moved_i);

endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
  import bbi_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [DW-1:0] wr_data_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          grant_i,
  output logic          bus_cyc_o,
  output logic [1:0]    bus_cmd_o,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe_o,
  input  logic [DW-1:0] bus_ad_i,
  output logic          init_rdy_o,
  input  logic          tgt_rdy_i,
  input  logic          tgt_stop_i,
  output logic          done_o,
  output logic [1:0]    done_status_o,
  output logic [LW-1:0] done_left_o,
  output logic [DW-1:0] done_addr_o
);
  bbi_state_e    state;
  logic          write_q, quit_q, load, step, last, moved;
  logic          loc_rdy;
  logic [DW-1:0] addr_q;
  logic [LW-1:0] left_q;
  logic [1:0]    status;
  logic          st_addr, st_turn, st_data;

  assign loc_rdy = write_q ? wr_valid_i : rd_ready_i;

  bbi_tracker #(.DW(DW), .LW(LW)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .addr_i  (req_addr_i),
    .len_i   (req_len_i),
    .step_i  (step),
    .addr_o  (addr_q),
    .left_o  (left_q),
    .moved_o (moved),
    .last_o  (last)
  );

  bbi_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .grant_i     (grant_i),
    .loc_rdy_i   (loc_rdy),
    .tgt_rdy_i   (tgt_rdy_i),
    .tgt_stop_i  (tgt_stop_i),
    .last_i      (last),
    .moved_i     (moved),
    .state_o     (state),
    .write_o     (write_q),
    .quit_o      (quit_q),
    .load_o      (load),
    .step_o      (step),
    .status_o    (status)
  );

  assign st_addr = (state == ST_ADDR);
  assign st_turn = (state == ST_TURN);
  assign st_data = (state == ST_DATA);

  assign req_ready_o = (state == ST_IDLE) && grant_i;
  assign bus_cyc_o   = st_addr || st_turn || (st_data && !last && !quit_q);
  assign bus_cmd_o   = st_addr ? (write_q ? CMD_WR : CMD_RD) : CMD_NONE;
  assign bus_ad_oe_o = st_addr || (st_data && write_q);
  assign bus_ad_o    = st_addr ? addr_q :
                       ((st_data && write_q) ? wr_data_i : '0);
  assign init_rdy_o  = st_data && loc_rdy;
  assign wr_ready_o  = st_data && write_q && tgt_rdy_i;
  assign rd_valid_o  = st_data && !write_q && tgt_rdy_i;
  assign rd_data_o   = bus_ad_i;

  assign done_o        = (state == ST_DONE);
  assign done_status_o = status;
  assign done_left_o   = left_q;
  assign done_addr_o   = addr_q;

  // R1: a taken request always carries at least one word
  a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |-> (req_len_i != '0));

  // R2: acceptance is followed by an address phase with a command
  a_r2_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (bus_cyc_o && bus_ad_oe_o && bus_cmd_o != CMD_NONE));

  // R4: a write word is only consumed when both sides are ready
  a_r4_wr_both_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o) |-> (init_rdy_o && tgt_rdy_i));

  // R4: a read word is only handed on when both sides are ready
  a_r4_rd_both_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_ready_i) |-> (init_rdy_o && tgt_rdy_i));

  // R5: while the burst-active line is high in data, more than one word is owed
  a_r5_cyc_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st_data && bus_cyc_o) |-> (left_q > LW'(1)));

  // R6: a read address phase is followed by an undriven turnaround
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == CMD_RD) |=> (bus_cyc_o && !bus_ad_oe_o));

  // R10: grant lost during data drops the burst-active line next cycle
  a_r10_grant_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (st_data && !grant_i) |=> !bus_cyc_o);

  // R11: the completion cycle leaves the shared lines undriven
  a_r11_done_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!bus_cyc_o && !bus_ad_oe_o));

endmodule

// File: tb/tb_burst_initiator.sv
`timescale 1ns/100ps
module tb_burst_initiator;
  localparam int DW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic          req_ready_o;
  logic [DW-1:0] req_addr_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic          wr_valid_i = 1'b0, wr_ready_o;
  logic [DW-1:0] wr_data_i = '0;
  logic          rd_valid_o, rd_ready_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic          grant_i = 1'b0;
  logic          bus_cyc_o, bus_ad_oe_o, init_rdy_o;
  logic [1:0]    bus_cmd_o;
  logic [DW-1:0] bus_ad_o, bus_ad_i = '0;
  logic          tgt_rdy_i = 1'b0, tgt_stop_i = 1'b0;
  logic          done_o;
  logic [1:0]    done_status_o;
  logic [LW-1:0] done_left_o;
  logic [DW-1:0] done_addr_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  burst_initiator #(.DW(DW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
    .grant_i(grant_i), .bus_cyc_o(bus_cyc_o), .bus_cmd_o(bus_cmd_o),
    .bus_ad_o(bus_ad_o), .bus_ad_oe_o(bus_ad_oe_o), .bus_ad_i(bus_ad_i),
    .init_rdy_o(init_rdy_o), .tgt_rdy_i(tgt_rdy_i), .tgt_stop_i(tgt_stop_i),
    .done_o(done_o), .done_status_o(done_status_o), .done_left_o(done_left_o),
    .done_addr_o(done_addr_o)
  );

  function automatic logic [DW-1:0] wpat(int n);
    return 32'hA500_0000 + 32'(n * 17);
  endfunction

  function automatic logic [DW-1:0] rpat(int n);
    return 32'h5A00_0F00 ^ 32'(n * 33);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One full burst with a scripted target and local stream; bit k of a mask is data cycle k
  task automatic do_burst(input bit wr, input logic [DW-1:0] a, input int len,
                          input logic [15:0] trdy, input logic [15:0] lrdy,
                          input int stop_cyc, input int gnt_cyc);
    int  n = 0;
    int  left = len;
    bit  quit = 0;
    bit  stopped = 0;
    bit  fin = 0;
    int  exp_st;
    @(posedge clk); #1;
    grant_i = 1; req_valid_i = 1; req_write_i = wr; req_addr_i = a; req_len_i = LW'(len);
    #1;
    chk(req_ready_o, "R1/R11 accept", {31'd0, req_ready_o}, 32'd1);
    @(posedge clk); #1;
    req_valid_i = 0;
    #1;
    chk(bus_cyc_o && bus_ad_oe_o, "R2 addr phase lines", {30'd0, bus_cyc_o, bus_ad_oe_o}, 32'd3);
    chk(bus_ad_o == a, "R2 addr value", bus_ad_o, a);
    chk(bus_cmd_o == (wr ? 2'b10 : 2'b01), "R2 cmd", {30'd0, bus_cmd_o}, wr ? 32'd2 : 32'd1);
    if (!wr) begin
      @(posedge clk); #2;
      chk(bus_cyc_o && !bus_ad_oe_o && bus_cmd_o == 2'b00, "R6 turnaround",
          {29'd0, bus_cyc_o, bus_ad_oe_o, |bus_cmd_o}, 32'd4);
    end
    for (int k = 0; k < 64 && !fin; k++) begin
      bit tr, lr, mv, sp, gn;
      @(posedge clk); #1;
      tr = trdy[k % 16]; lr = lrdy[k % 16];
      sp = (k == stop_cyc); gn = (k < gnt_cyc);
      tgt_rdy_i = tr; tgt_stop_i = sp; grant_i = gn;
      if (wr) wr_valid_i = lr; else rd_ready_i = lr;
      wr_data_i = wpat(n); bus_ad_i = rpat(n);
      #1;
      chk(init_rdy_o == lr, "R7 initiator ready", {31'd0, init_rdy_o}, {31'd0, lr});
      chk(bus_cyc_o == (left > 1 && !quit), "R5/R10 cyc line", {31'd0, bus_cyc_o},
          {31'd0, (left > 1 && !quit)});
      mv = tr && lr;
      if (wr) begin
        if (!tr) chk(!wr_ready_o, "R4 write held by target", {31'd0, wr_ready_o}, 32'd0);
        if (mv) begin
          chk(wr_ready_o && bus_ad_oe_o, "R3 write drive", {30'd0, wr_ready_o, bus_ad_oe_o}, 32'd3);
          chk(bus_ad_o == wpat(n), "R3 write word", bus_ad_o, wpat(n));
        end
      end else begin
        chk(!bus_ad_oe_o, "R6 read undriven", {31'd0, bus_ad_oe_o}, 32'd0);
        if (!tr) chk(!rd_valid_o, "R4 read held by target", {31'd0, rd_valid_o}, 32'd0);
        if (mv) begin
          chk(rd_valid_o, "R4 read offered", {31'd0, rd_valid_o}, 32'd1);
          chk(rd_data_o == rpat(n), "R3 read word", rd_data_o, rpat(n));
        end
      end
      fin = sp || (mv && (left == 1 || quit));
      if (sp) stopped = 1;
      if (mv) begin n++; left--; end
      if (!gn) quit = 1;
    end
    @(posedge clk); #1;
    tgt_rdy_i = 0; tgt_stop_i = 0; wr_valid_i = 0; rd_ready_i = 0; grant_i = 1;
    #1;
    if (left == 0) exp_st = 0;
    else if (stopped) exp_st = (n == 0) ? 1 : 2;
    else exp_st = 3;
    chk(done_o, "R8 done pulse", {31'd0, done_o}, 32'd1);
    chk(done_status_o == 2'(exp_st), (exp_st == 3) ? "R10 status" : (exp_st == 0 ? "R8 status" : "R9 status"),
        {30'd0, done_status_o}, 32'(exp_st));
    chk(done_left_o == LW'(left), stopped ? "R9 words left" : "R8 words left",
        {24'd0, done_left_o}, 32'(left));
    chk(done_addr_o == a + 32'(4 * n), stopped ? "R9 resume addr" : "R8 resume addr",
        done_addr_o, a + 32'(4 * n));
    chk(!bus_cyc_o && !bus_ad_oe_o, "R11 bus released", {30'd0, bus_cyc_o, bus_ad_oe_o}, 32'd0);
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk(!bus_cyc_o && !bus_ad_oe_o && !done_o && !init_rdy_o, "R1 reset idle",
        {28'd0, bus_cyc_o, bus_ad_oe_o, done_o, init_rdy_o}, 32'd0);
    chk(!req_ready_o, "R1 no grant no accept", {31'd0, req_ready_o}, 32'd0);
  endtask

  task automatic t_no_grant();
    @(posedge clk); #1;
    grant_i = 0; req_valid_i = 1; req_write_i = 1; req_addr_i = 32'h40; req_len_i = 8'd2;
    #1;
    chk(!req_ready_o, "R1 held off without grant", {31'd0, req_ready_o}, 32'd0);
    @(posedge clk); #2;
    chk(!bus_cyc_o && bus_cmd_o == 2'b00, "R1 bus stays idle", {29'd0, bus_cyc_o, bus_cmd_o}, 32'd0);
    req_valid_i = 0;
  endtask

  task automatic t_write_full();     do_burst(1, 32'h0000_1000, 4, 16'hFFFF, 16'hFFFF, 99, 99); endtask
  task automatic t_read_twait();     do_burst(0, 32'h0000_2000, 3, 16'hFFF5, 16'hFFFF, 99, 99); endtask
  task automatic t_write_lstall();   do_burst(1, 32'h0000_3000, 3, 16'hFFFF, 16'hFFE6, 99, 99); endtask
  task automatic t_read_lstall();    do_burst(0, 32'h0000_4000, 2, 16'hFFFF, 16'hFFFA, 99, 99); endtask
  task automatic t_stop_retry();     do_burst(1, 32'h0000_5000, 4, 16'hFFFE, 16'hFFFF, 0, 99); endtask
  task automatic t_stop_with_word(); do_burst(0, 32'h0000_6000, 5, 16'hFFFF, 16'hFFFF, 2, 99); endtask
  task automatic t_stop_no_word();   do_burst(1, 32'h0000_7000, 4, 16'hFFFB, 16'hFFFF, 2, 99); endtask
  task automatic t_grant_drop();     do_burst(1, 32'h0000_8000, 6, 16'hFFFF, 16'hFFFF, 99, 1); endtask
  task automatic t_single();         do_burst(1, 32'h0000_9000, 1, 16'hFFFF, 16'hFFFF, 99, 99); endtask
  task automatic t_parked();         do_burst(0, 32'h0000_A000, 2, 16'hFFFF, 16'hFFFF, 99, 99); endtask

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_no_grant();
    t_write_full();
    t_read_twait();
    t_write_lstall();
    t_read_lstall();
    t_stop_retry();
    t_stop_with_word();
    t_stop_no_word();
    t_grant_drop();
    t_single();
    t_parked();
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule